// File: doc/BRIEF.md
# Cluster Steering Decision Unit

This block picks the destination cluster for one renamed instruction in a core split into a ring of execution clusters, and reports which of its source operands must be copied into that cluster. For each source operand it receives a ready flag, a mask of the clusters that currently hold a copy of the value, and the cluster that will produce the value if it is still pending. It also receives the current occupancy of every cluster. A locality filter first narrows the set of candidate clusters. A load picker then takes the least occupied candidate. When the clusters are badly out of balance, the filter is bypassed and the choice rests on load alone.

Two locality policies are available through a static mode pin. The copy-count policy prefers clusters that need the fewest operand copies. The ring-distance policy prefers clusters whose farthest required operand is nearest on the ring. Instructions enter through a valid/ready handshake. An accepted instruction is decided combinationally and registered, so the decision is offered on the output one cycle later. The output holds steady under back-pressure, and a new instruction is accepted only when the output register is empty or is being drained in the same cycle. An instruction with fewer operands presents each unused operand as ready, with every bit of its holder mask set.

Top module: `cl_steer_unit`

## Requirements
- R1: With every operand ready and the copy-count policy selected (cfg_topo_mode=0), the candidates are the clusters with the fewest operands not held locally. A cluster counts as local for an operand when that cluster's bit is set in the operand's holder mask (bit c of the operand's slice is cluster c), so a value held in several clusters is local in each of them.
- R2: When any operand is not ready, the only candidate is the producer cluster of the lowest-numbered pending operand, whatever the policy.
- R3: Among the candidates, the cluster with the smallest occupancy is chosen, and equal occupancies go to the lowest cluster index.
- R4: When the largest occupancy minus the smallest exceeds cfg_imb_thresh, every cluster is a candidate and R1, R2 and R5 are skipped. A difference equal to the threshold does not trigger this.
- R5: With every operand ready and cfg_topo_mode=1, the candidates are the clusters that minimise, over the operands, the ring distance to the nearest holder. The distance between clusters i and j is min(|i-j|, N-|i-j|).
- R6: Bit s of out_copy is set when operand s is ready and not held in the chosen cluster, or when it is pending and its producer is not the chosen cluster.
- R7: An instruction is accepted on a rising edge with in_valid and in_ready high, and its decision appears with out_valid on the next cycle. in_ready equals !out_valid || out_ready.
- R8: While out_valid is high and out_ready is low, out_valid, out_cluster and out_copy hold their values.
- R9: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_topo_mode | input | 1 | 0: copy-count policy, 1: ring-distance policy |
| cfg_imb_thresh | input | OCC_W | Imbalance limit above which locality is skipped |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Unit can take the instruction |
| in_src_rdy | input | NUM_SRC | Per-operand ready flag |
| in_src_loc | input | NUM_SRC*NUM_CL | Per-operand holder mask, operand s at bits s*NUM_CL upward |
| in_src_prod | input | NUM_SRC*clog2(NUM_CL) | Per-operand producer cluster for pending operands |
| in_occ | input | NUM_CL*OCC_W | Per-cluster occupancy, cluster c at bits c*OCC_W upward |
| out_valid | output | 1 | Decision available |
| out_ready | input | 1 | Consumer takes the decision |
| out_cluster | output | clog2(NUM_CL) | Chosen cluster |
| out_copy | output | NUM_SRC | Operands needing a copy into the chosen cluster |

## Verification
The bench builds the unit with four clusters, two operands and five-bit occupancies. With these values every ring distance of 0, 1 and 2 occurs, and one holder-mask arrangement separates the two policies. A threshold can also sit exactly at, or one below, the occupancy spread. Random occupancies up to 15 against random thresholds up to 31 exercise both sides of the imbalance override. A randomly toggled out_ready exercises back-pressure.

// File: rtl/cl_steer_pkg.sv
package cl_steer_pkg;

  // Shortest hop count between two positions on a ring of n nodes.
  function automatic int unsigned ring_dist(input int unsigned a, input int unsigned b,
                                            input int unsigned n);
    int unsigned d;
    d = (a > b) ? (a - b) : (b - a);
    return ((n - d) < d) ? (n - d) : d;
  endfunction

endpackage

// File: rtl/steer_imbalance.sv
module steer_imbalance #(
  parameter int NUM_CL = 4,
  parameter int OCC_W  = 5
) (
  input  logic [NUM_CL*OCC_W-1:0] occ,
  input  logic [OCC_W-1:0]        thresh,
  output logic                    over
);
  logic [OCC_W-1:0] hi, lo;

  always_comb begin
    hi = occ[OCC_W-1:0];
    lo = occ[OCC_W-1:0];
    for (int c = 1; c < NUM_CL; c++) begin
      if (occ[c*OCC_W +: OCC_W] > hi) hi = occ[c*OCC_W +: OCC_W];
      if (occ[c*OCC_W +: OCC_W] < lo) lo = occ[c*OCC_W +: OCC_W];
    end
    over = (hi - lo) > thresh;
  end
endmodule

// File: rtl/steer_locality.sv
module steer_locality
  import cl_steer_pkg::*;
#(
  parameter int NUM_CL  = 4,
  parameter int NUM_SRC = 2,
  localparam int IW     = $clog2(NUM_CL)
) (
  input  logic                      topo,
  input  logic [NUM_SRC-1:0]        src_rdy,
  input  logic [NUM_SRC*NUM_CL-1:0] src_loc,
  input  logic [NUM_SRC*IW-1:0]     src_prod,
  output logic [NUM_CL-1:0]         cand
);
  int unsigned cost [NUM_CL];
  int unsigned best_cost;
  int unsigned pend_cl;
  logic        pend;

  always_comb begin
    pend    = 1'b0;
    pend_cl = 0;
    for (int s = NUM_SRC - 1; s >= 0; s--) begin
      if (!src_rdy[s]) begin
        pend    = 1'b1;
        pend_cl = 32'(src_prod[s*IW +: IW]);
      end
    end

    for (int c = 0; c < NUM_CL; c++) begin
      int unsigned misses, far, near;
      misses = 0;
      far    = 0;
      for (int s = 0; s < NUM_SRC; s++) begin
        if (!src_loc[s*NUM_CL + c]) misses++;
        near = NUM_CL;
        for (int h = 0; h < NUM_CL; h++) begin
          if (src_loc[s*NUM_CL + h] &&
              ring_dist(32'(c), 32'(h), 32'(NUM_CL)) < near)
            near = ring_dist(32'(c), 32'(h), 32'(NUM_CL));
        end
        if (near == NUM_CL) near = 0;
        if (near > far) far = near;
      end
      cost[c] = topo ? far : misses;
    end

    best_cost = cost[0];
    for (int c = 1; c < NUM_CL; c++)
      if (cost[c] < best_cost) best_cost = cost[c];

    for (int c = 0; c < NUM_CL; c++)
      cand[c] = (cost[c] == best_cost);

    if (pend) cand = NUM_CL'(1) << pend_cl;
  end
endmodule

// File: rtl/steer_pick.sv
module steer_pick #(
  parameter int NUM_CL = 4,
  parameter int OCC_W  = 5,
  localparam int IW    = $clog2(NUM_CL)
) (
  input  logic [NUM_CL-1:0]       cand,
  input  logic                    over,
  input  logic [NUM_CL*OCC_W-1:0] occ,
  output logic [IW-1:0]           sel
);
  logic [NUM_CL-1:0] eff;
  logic [OCC_W-1:0]  best_occ;
  logic              found;

  always_comb begin
    eff      = over ? {NUM_CL{1'b1}} : cand;
    sel      = '0;
    best_occ = '0;
    found    = 1'b0;
    for (int c = 0; c < NUM_CL; c++) begin
      if (eff[c] && (!found || occ[c*OCC_W +: OCC_W] < best_occ)) begin
        found    = 1'b1;
        best_occ = occ[c*OCC_W +: OCC_W];
        sel      = IW'(c);
      end
    end
  end
endmodule

// File: rtl/cl_steer_unit.sv
module cl_steer_unit #(
  parameter int NUM_CL  = 4,
  parameter int NUM_SRC = 2,
  parameter int OCC_W   = 5
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cfg_topo_mode,
  input  logic [OCC_W-1:0]                   cfg_imb_thresh,
  input  logic                               in_valid,
  output logic                               in_ready,
  input  logic [NUM_SRC-1:0]                 in_src_rdy,
  input  logic [NUM_SRC*NUM_CL-1:0]          in_src_loc,
  input  logic [NUM_SRC*$clog2(NUM_CL)-1:0]  in_src_prod,
  input  logic [NUM_CL*OCC_W-1:0]            in_occ,
  output logic                               out_valid,
  input  logic                               out_ready,
  output logic [$clog2(NUM_CL)-1:0]          out_cluster,
  output logic [NUM_SRC-1:0]                 out_copy
);
  localparam int IW = $clog2(NUM_CL);

  logic [NUM_CL-1:0]  cand;
  logic               over;
  logic [IW-1:0]      sel;
  logic [NUM_SRC-1:0] copy_need;
  logic               take;

  steer_imbalance #(.NUM_CL(NUM_CL), .OCC_W(OCC_W)) imb_i (
    .occ(in_occ), .thresh(cfg_imb_thresh), .over(over)
  );

  steer_locality #(.NUM_CL(NUM_CL), .NUM_SRC(NUM_SRC)) loc_i (
    .topo(cfg_topo_mode), .src_rdy(in_src_rdy), .src_loc(in_src_loc),
    .src_prod(in_src_prod), .cand(cand)
  );

  steer_pick #(.NUM_CL(NUM_CL), .OCC_W(OCC_W)) pick_i (
    .cand(cand), .over(over), .occ(in_occ), .sel(sel)
  );

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_copy
    assign copy_need[s] = in_src_rdy[s] ? !in_src_loc[s*NUM_CL + int'(sel)]
                                        : (in_src_prod[s*IW +: IW] != sel);
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_cluster <= '0;
      out_copy    <= '0;
    end else begin
      if (take) begin
        out_valid   <= 1'b1;
        out_cluster <= sel;
        out_copy    <= copy_need;
      end else if (out_ready) begin
        out_valid   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cl_steer_unit_chk.sv
module cl_steer_unit_chk #(
  parameter int NUM_CL  = 4,
  parameter int NUM_SRC = 2,
  parameter int OCC_W   = 5
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic                               cfg_topo_mode,
  input logic [OCC_W-1:0]                   cfg_imb_thresh,
  input logic                               in_valid,
  input logic                               in_ready,
  input logic [NUM_SRC-1:0]                 in_src_rdy,
  input logic [NUM_SRC*NUM_CL-1:0]          in_src_loc,
  input logic [NUM_SRC*$clog2(NUM_CL)-1:0]  in_src_prod,
  input logic [NUM_CL*OCC_W-1:0]            in_occ,
  input logic                               out_valid,
  input logic                               out_ready,
  input logic [$clog2(NUM_CL)-1:0]          out_cluster,
  input logic [NUM_SRC-1:0]                 out_copy
);
  localparam int IW = $clog2(NUM_CL);

  logic [NUM_SRC*NUM_CL-1:0] cap_loc;
  logic [NUM_SRC-1:0]        cap_rdy;
  logic [NUM_CL*OCC_W-1:0]   cap_occ;
  logic                      cap_over;
  logic                      in_over;
  logic [OCC_W-1:0]          hi, lo, cap_min, sel_occ;

  always_comb begin
    hi = '0;
    lo = '1;
    for (int c = 0; c < NUM_CL; c++) begin
      if (in_occ[c*OCC_W +: OCC_W] > hi) hi = in_occ[c*OCC_W +: OCC_W];
      if (in_occ[c*OCC_W +: OCC_W] < lo) lo = in_occ[c*OCC_W +: OCC_W];
    end
    in_over = (hi - lo) > cfg_imb_thresh;
    cap_min = '1;
    for (int c = 0; c < NUM_CL; c++)
      if (cap_occ[c*OCC_W +: OCC_W] < cap_min) cap_min = cap_occ[c*OCC_W +: OCC_W];
    sel_occ = cap_occ[int'(out_cluster)*OCC_W +: OCC_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_loc  <= '0;
      cap_rdy  <= '0;
      cap_occ  <= '0;
      cap_over <= 1'b0;
    end else if (in_valid && in_ready) begin
      cap_loc  <= in_src_loc;
      cap_rdy  <= in_src_rdy;
      cap_occ  <= in_occ;
      cap_over <= in_over;
    end
  end

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_cluster) && $stable(out_copy));

  assert_accept_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  assert_pending_producer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_src_rdy[0] && (cfg_imb_thresh == '1)
    |=> out_cluster == $past(in_src_prod[IW-1:0]));

  assert_override_min_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cap_over |-> sel_occ == cap_min);

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_cp
    assert_copy_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && cap_rdy[s] |-> out_copy[s] == !cap_loc[s*NUM_CL + int'(out_cluster)]);
  end
endmodule

bind cl_steer_unit cl_steer_unit_chk #(
  .NUM_CL(NUM_CL), .NUM_SRC(NUM_SRC), .OCC_W(OCC_W)
) chk_i (.*);

// File: tb/cl_steer_unit_tb_top.sv
module cl_steer_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_topo_mode = 1'b0;
  logic [4:0]  cfg_imb_thresh = 5'd31;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_src_rdy = 2'b11;
  logic [7:0]  in_src_loc = 8'hFF;
  logic [3:0]  in_src_prod = 4'h0;
  logic [19:0] in_occ = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [1:0]  out_cluster;
  logic [1:0]  out_copy;

  int checks = 0;
  int errors = 0;
  bit rnd_ready = 1'b0;
  bit done = 1'b0;
  logic [3:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  cl_steer_unit dut_i (.*);

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Reference decision: {cluster, copy mask}
  function automatic logic [3:0] model(input logic [1:0] rdy, input logic [7:0] loc,
                                       input logic [3:0] prod, input logic [19:0] occ,
                                       input logic [4:0] th, input logic topo,
                                       output string tag);
    int o[4];
    int mx = 0, mn = 1000, score[4], bs, pick, po;
    logic [3:0] cand;
    logic [1:0] cp;
    for (int c = 0; c < 4; c++) begin
      o[c] = int'(occ[c*5 +: 5]);
      if (o[c] > mx) mx = o[c];
      if (o[c] < mn) mn = o[c];
    end
    if (mx - mn > int'(th)) begin
      cand = 4'hF; tag = "R4";
    end else if (!rdy[0]) begin
      cand = 4'b1 << prod[1:0]; tag = "R2";
    end else if (!rdy[1]) begin
      cand = 4'b1 << prod[3:2]; tag = "R2";
    end else begin
      tag = topo ? "R5" : "R1";
      for (int c = 0; c < 4; c++) begin
        score[c] = 0;
        for (int s = 0; s < 2; s++) begin
          if (topo) begin
            int best = 9;
            for (int h = 0; h < 4; h++) if (loc[s*4+h]) begin
              int d = (c > h) ? c - h : h - c;
              if (4 - d < d) d = 4 - d;
              if (d < best) best = d;
            end
            if (best == 9) best = 0;
            if (best > score[c]) score[c] = best;
          end else if (!loc[s*4+c]) score[c]++;
        end
      end
      bs = score[0];
      for (int c = 1; c < 4; c++) if (score[c] < bs) bs = score[c];
      for (int c = 0; c < 4; c++) cand[c] = (score[c] == bs);
    end
    pick = -1; po = 1000;
    for (int c = 0; c < 4; c++) if (cand[c] && o[c] < po) begin pick = c; po = o[c]; end
    for (int s = 0; s < 2; s++)
      cp[s] = rdy[s] ? !loc[s*4+pick] : (int'(prod[s*2 +: 2]) != pick);
    return {2'(pick), cp};
  endfunction

  task automatic send(input logic [1:0] rdy, input logic [7:0] loc, input logic [3:0] prod,
                      input logic [19:0] occ, input logic [4:0] th, input logic topo);
    string t;
    logic [3:0] e;
    in_src_rdy = rdy; in_src_loc = loc; in_src_prod = prod;
    in_occ = occ; cfg_imb_thresh = th; cfg_topo_mode = topo;
    in_valid = 1'b1;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    e = model(rdy, loc, prod, occ, th, topo, t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  function automatic logic [19:0] occ4(input int a, input int b, input int c, input int d);
    return {5'(d), 5'(c), 5'(b), 5'(a)};
  endfunction

  // Monitor: a transfer completes at the edge after this sample.
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check("R7 unexpected output", 1, 0);
      end else begin
        logic [3:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({t, " cluster"}, int'(out_cluster), int'(e[3:2]));
        check("R6 copy mask", int'(out_copy), int'(e[1:0]));
      end
    end
  end

  always @(posedge clk) begin
    #1;
    if (rnd_ready) out_ready = ($urandom % 4) != 0;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check("R7 watchdog expired", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 out_valid after reset", int'(out_valid), 0);
    check("R9 in_ready after reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 vs R5: operand 0 in cluster 0, operand 1 in cluster 2
    send(2'b11, 8'b0100_0001, 4'h0, occ4(3, 3, 3, 3), 5'd31, 1'b0); // R1 -> 0, copy 10
    send(2'b11, 8'b0100_0001, 4'h0, occ4(3, 3, 3, 3), 5'd31, 1'b1); // R5 -> 1, copy 11
    // R1: value replicated in clusters 1 and 3 wins cluster 3 despite higher load
    send(2'b11, 8'b1000_1010, 4'h0, occ4(1, 1, 1, 6), 5'd10, 1'b0);
    // R2 and R4 boundary: spread 5 equals threshold -> producer 2
    send(2'b01, 8'b0000_1000, 4'b1000, occ4(1, 1, 6, 1), 5'd5, 1'b0);
    // R4: spread 5 exceeds 4 -> least loaded cluster 0
    send(2'b01, 8'b0000_1000, 4'b1000, occ4(1, 1, 6, 1), 5'd4, 1'b0);
    // R3: ties to lowest index, then strictly least loaded
    send(2'b11, 8'hFF, 4'h0, occ4(2, 2, 2, 2), 5'd31, 1'b0);
    send(2'b11, 8'hFF, 4'h0, occ4(3, 2, 2, 5), 5'd31, 1'b1);

    // R8 and R7: stall the output and watch it hold
    @(negedge clk); while (exp_q.size() != 0) @(negedge clk);
    @(posedge clk); #1 out_ready = 1'b0;
    send(2'b11, 8'b0010_0100, 4'h0, occ4(0, 0, 0, 0), 5'd31, 1'b0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R8 out_valid held", int'(out_valid), 1);
      check("R8 cluster held", int'(out_cluster), int'(exp_q[0][3:2]));
      check("R7 in_ready low while stalled", int'(in_ready), 0);
    end
    @(posedge clk); #1 out_ready = 1'b1;

    // Random mix with back-pressure
    rnd_ready = 1'b1;
    for (int n = 0; n < 1500; n++) begin
      logic [7:0] loc;
      logic [1:0] rdy;
      loc = 8'($urandom);
      if (loc[3:0] == 0) loc[0] = 1'b1;
      if (loc[7:4] == 0) loc[4] = 1'b1;
      rdy = (($urandom % 3) == 0) ? 2'($urandom) : 2'b11;
      send(rdy, loc, 4'($urandom),
           occ4($urandom % 16, $urandom % 16, $urandom % 16, $urandom % 16),
           5'($urandom % 32), 1'($urandom));
    end
    rnd_ready = 1'b0;
    @(posedge clk); #1 out_ready = 1'b1;
    @(negedge clk); while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule